// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates five interrupt sources for a small 8-bit processor core: two external request lines, two timer overflow events and one serial source. The serial source is the OR of a receive-complete and a transmit-complete level. The external and timer events arrive as one-cycle set pulses. The block latches them into request flags. Software loads an enable register, with one bit per source plus a global enable, and a priority register, with one bit per source. The core strobes `insn_done` whenever an instruction finishes.

At each instruction boundary the controller may choose one pending, enabled request. It then issues a one-cycle acknowledge with the handler's vector address. A handler at the low level can be preempted by a high-level request. A handler at the high level cannot be preempted. A two-bit active-level register records which levels are in service. The core's return-from-interrupt strobe releases the innermost level.

Top module: `intc_two_level`

## Requirements
- R1: A one-cycle pulse on `evt_set[i]` sets flag i of `flag_q`, and the flag stays set until hardware clears it. Bit 0 is external 0, bit 1 is timer 0, bit 2 is external 1 and bit 3 is timer 1.
- R2: A request can be accepted only when its enable bit `ie_din[i]` and the global bit `ie_din[5]` were both written as 1. Index i follows the order external 0, timer 0, external 1, timer 1, serial. A request with either bit clear stays pending and is not acknowledged.
- R3: Bit i of the priority register, written through `ip_din[i]`, places source i at the high level (1) or the low level (0).
- R4: While a high-level handler is active, nothing is accepted. While only a low-level handler is active, only high-level requests are accepted, and such a request preempts the low-level handler.
- R5: With no handler active, any enabled pending request is accepted, whatever its level.
- R6: When requests are pending at both levels, a high-level request is taken first.
- R7: Among requests at the same level, the winner is the first in the order external 0, timer 0, external 1, timer 1, serial.
- R8: The vector is 0x0003 + 8·i: external 0 gives 0x0003, timer 0 gives 0x000B, external 1 gives 0x0013, timer 1 gives 0x001B and serial gives 0x0023.
- R9: Acceptance clears the chosen flag in `flag_q`. The serial source is never cleared by the block, so it is taken again while its input levels stay high.
- R10: Acceptance happens only in a cycle where `insn_done` is high. `ack` is a one-cycle pulse in the following cycle, and at most one acknowledge is issued per boundary.
- R11: `active_lvl[0]` marks the low level as active and `active_lvl[1]` marks the high level as active. An acceptance sets the bit of its level. `reti` clears the high bit if it is set, and otherwise clears the low bit.
- R12: After reset, `ack`, `vec_addr`, `flag_q`, `active_lvl` and both configuration registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | 4 | Set pulses for the external and timer flags |
| ser_rx_done | input | 1 | Serial receive-complete level |
| ser_tx_done | input | 1 | Serial transmit-complete level |
| ie_wr | input | 1 | Write strobe for the enable register |
| ie_din | input | 6 | Per-source enables [4:0] and the global enable [5] |
| ip_wr | input | 1 | Write strobe for the priority register |
| ip_din | input | 5 | Per-source priority, 1 = high |
| insn_done | input | 1 | Instruction-boundary strobe from the core |
| reti | input | 1 | Return-from-interrupt strobe from the core |
| ack | output | 1 | One-cycle acknowledge of an accepted request |
| ack_src | output | 3 | Index of the accepted source |
| vec_addr | output | 16 | Handler vector address, valid with `ack` |
| flag_q | output | 4 | Latched external and timer request flags |
| active_lvl | output | 2 | Active levels: [0] low, [1] high |

## Verification
Every result of the block has a fixed latency. An acceptance made in a boundary cycle shows up one clock later in `ack` and `vec_addr`. The cleared flag and the updated active level become visible in that same following cycle. A `reti` changes `active_lvl` one cycle after its strobe. The driver marks each expected result with the clock count at which it is due. The monitor compares only in that cycle, 2 ns after the edge, and reports any acknowledge for which no result was queued.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NSRC  = 5;
    localparam int NHW   = 4;
    localparam int SRC_W = $clog2(NSRC);

    typedef struct packed {
        logic             valid;
        logic             hi;
        logic [SRC_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } lvl_t;

    // lowest set index wins
    function automatic pick_t first_of(input logic [NSRC-1:0] m, input logic hi);
        pick_t p;
        p    = '0;
        p.hi = hi;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (m[i]) begin
                p.valid = 1'b1;
                p.idx   = SRC_W'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/intc_flags.sv
module intc_flags
    import intc_pkg::*;
#(
    parameter int N = NHW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr) | set;
    end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] en,
    input  logic            gen,
    input  logic [NSRC-1:0] prio,
    input  lvl_t            act,
    output pick_t           pick
);
    logic [NSRC-1:0] req, hi_m, lo_m;
    pick_t hp, lp;

    always_comb begin
        req  = pend & en & {NSRC{gen}};
        hi_m = req & prio;
        lo_m = req & ~prio;
        hp   = first_of(hi_m, 1'b1);
        lp   = first_of(lo_m, 1'b0);
        pick = '0;
        if (!act.hi) begin
            if (hp.valid)    pick = hp;
            else if (!act.lo) pick = lp;
        end
    end
endmodule

// File: rtl/intc_level_track.sv
module intc_level_track
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic take_hi,
    input  logic reti,
    output lvl_t act
);
    lvl_t nxt;

    always_comb begin
        nxt = act;
        if (reti) begin
            if (act.hi) nxt.hi = 1'b0;
            else        nxt.lo = 1'b0;
        end
        if (take) begin
            if (take_hi) nxt.hi = 1'b1;
            else         nxt.lo = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) act <= '0;
        else     act <= nxt;
    end
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level
    import intc_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0003,
    parameter int                VEC_STEP = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        evt_set,
    input  logic              ser_rx_done,
    input  logic              ser_tx_done,
    input  logic              ie_wr,
    input  logic [5:0]        ie_din,
    input  logic              ip_wr,
    input  logic [4:0]        ip_din,
    input  logic              insn_done,
    input  logic              reti,
    output logic              ack,
    output logic [2:0]        ack_src,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [3:0]        flag_q,
    output logic [1:0]        active_lvl
);
    localparam int GBIT = NSRC;

    logic [NSRC:0]   ie_q;
    logic [NSRC-1:0] ip_q;
    logic [NHW-1:0]  hw_clr;
    logic [NSRC-1:0] pend;
    logic            take;
    pick_t           pick;
    lvl_t            act;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q <= '0;
            ip_q <= '0;
        end else begin
            if (ie_wr) ie_q <= ie_din;
            if (ip_wr) ip_q <= ip_din;
        end
    end

    intc_flags #(.N(NHW)) u_flags (
        .clk (clk),
        .rst (rst),
        .set (evt_set),
        .clr (hw_clr),
        .q   (flag_q)
    );

    assign pend = {ser_rx_done | ser_tx_done, flag_q};

    intc_arbiter u_arb (
        .pend (pend),
        .en   (ie_q[NSRC-1:0]),
        .gen  (ie_q[GBIT]),
        .prio (ip_q),
        .act  (act),
        .pick (pick)
    );

    assign take = insn_done & pick.valid;

    // serial source has no hardware clear
    generate
        for (genvar g = 0; g < NHW; g++) begin : g_clr
            assign hw_clr[g] = take && (pick.idx == SRC_W'(g));
        end
    endgenerate

    intc_level_track u_lvl (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .take_hi (pick.hi),
        .reti    (reti),
        .act     (act)
    );

    assign active_lvl = {act.hi, act.lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            ack      <= 1'b0;
            ack_src  <= '0;
            vec_addr <= '0;
        end else begin
            ack <= take;
            if (take) begin
                ack_src  <= pick.idx;
                vec_addr <= VEC_BASE + ADDR_W'(VEC_STEP) * ADDR_W'(pick.idx);
            end
        end
    end
endmodule

// File: rtl/intc_two_level_chk.sv
module intc_two_level_chk #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0003,
    parameter int                VEC_STEP = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              insn_done,
    input logic              reti,
    input logic              ack,
    input logic [ADDR_W-1:0] vec_addr,
    input logic [1:0]        active_lvl,
    input logic              glb_en
);
    logic [ADDR_W-1:0] vec_off;
    assign vec_off = vec_addr - VEC_BASE;

    // R10
    p_ack_on_boundary_r10: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(insn_done));
    // R10
    p_ack_single_r10: assert property (@(posedge clk) disable iff (rst)
        (ack && !insn_done) |=> !ack);
    // R2
    p_global_gate_r2: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(glb_en));
    // R4
    p_high_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        ack |-> !$past(active_lvl[1]));
    // R11
    p_level_set_r11: assert property (@(posedge clk) disable iff (rst)
        ack |-> (active_lvl != 2'b00));
    // R8
    p_vec_grid_r8: assert property (@(posedge clk) disable iff (rst)
        ack |-> ((int'(vec_off) % VEC_STEP) == 0));
    // R11
    p_reti_hi_r11: assert property (@(posedge clk) disable iff (rst)
        (reti && !insn_done && active_lvl[1]) |=> !active_lvl[1]);
    // R11
    p_reti_lo_r11: assert property (@(posedge clk) disable iff (rst)
        (reti && !insn_done && active_lvl == 2'b01) |=> (active_lvl == 2'b00));
endmodule

bind intc_two_level intc_two_level_chk #(
    .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .insn_done  (insn_done),
    .reti       (reti),
    .ack        (ack),
    .vec_addr   (vec_addr),
    .active_lvl (active_lvl),
    .glb_en     (ie_q[5])
);

// File: tb/intc_two_level_test.sv
module intc_two_level_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  evt_set = '0;
    logic        ser_rx_done = 1'b0, ser_tx_done = 1'b0;
    logic        ie_wr = 1'b0, ip_wr = 1'b0;
    logic [5:0]  ie_din = '0;
    logic [4:0]  ip_din = '0;
    logic        insn_done = 1'b0, reti = 1'b0;
    logic        ack;
    logic [2:0]  ack_src;
    logic [15:0] vec_addr;
    logic [3:0]  flag_q;
    logic [1:0]  active_lvl;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic        a;
        logic [15:0] v;
        string       req;
    } item_t;
    item_t exp_q[$];

    always #4 clk = ~clk;

    intc_two_level uut (
        .clk(clk), .rst(rst), .evt_set(evt_set),
        .ser_rx_done(ser_rx_done), .ser_tx_done(ser_tx_done),
        .ie_wr(ie_wr), .ie_din(ie_din), .ip_wr(ip_wr), .ip_din(ip_din),
        .insn_done(insn_done), .reti(reti),
        .ack(ack), .ack_src(ack_src), .vec_addr(vec_addr),
        .flag_q(flag_q), .active_lvl(active_lvl)
    );

    always @(posedge clk) cyc = cyc + 1;

    // monitor
    always @(posedge clk) begin
        #2;
        if (!rst && exp_q.size() > 0 && exp_q[0].due == cyc) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (ack !== it.a || (it.a && vec_addr !== it.v)) begin
                fails++;
                $display("FAIL %s ack/vec actual=%b/%h expected=%b/%h",
                         it.req, ack, vec_addr, it.a, it.v);
            end
        end else if (ack === 1'b1) begin
            checks++;
            fails++;
            $display("FAIL R10 unexpected ack actual=1 expected=0 vec=%h", vec_addr);
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bnd(input logic a, input logic [15:0] v, input string req);
        item_t it;
        @(negedge clk);
        insn_done = 1'b1;
        it.due = cyc + 1; it.a = a; it.v = v; it.req = req;
        exp_q.push_back(it);
        @(negedge clk);
        insn_done = 1'b0;
    endtask

    task automatic do_reti();
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
    endtask

    task automatic raise(input logic [3:0] m);
        @(negedge clk); evt_set = m;
        @(negedge clk); evt_set = '0;
    endtask

    task automatic wr_ie(input logic [5:0] d);
        @(negedge clk); ie_wr = 1'b1; ie_din = d;
        @(negedge clk); ie_wr = 1'b0;
    endtask

    task automatic wr_ip(input logic [4:0] d);
        @(negedge clk); ip_wr = 1'b1; ip_din = d;
        @(negedge clk); ip_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12 ack", {15'd0, ack}, 16'd0);
        check("R12 vec", vec_addr, 16'd0);
        check("R12 flags", {12'd0, flag_q}, 16'd0);
        check("R12 level", {14'd0, active_lvl}, 16'd0);

        // R2: global enable off blocks; R1 flag latch
        wr_ie(6'b000001);
        raise(4'b0001);
        check("R1 flag latched", {12'd0, flag_q}, 16'h0001);
        bnd(1'b0, 16'h0, "R2 global off");
        check("R2 flag kept", {12'd0, flag_q}, 16'h0001);

        // R5 idle accepts, R9 clear, R11 level
        wr_ie(6'b100001);
        bnd(1'b1, 16'h0003, "R5 idle accept");
        check("R9 flag cleared", {12'd0, flag_q}, 16'h0000);
        check("R11 low set", {14'd0, active_lvl}, 16'h0001);

        // R4 low cannot preempt low
        wr_ie(6'b101111);
        raise(4'b1000);
        bnd(1'b0, 16'h0, "R4 low vs low");
        do_reti();
        check("R11 reti low", {14'd0, active_lvl}, 16'h0000);
        bnd(1'b1, 16'h001B, "R5 pending taken");
        do_reti();

        // R7 polling order
        raise(4'b1111);
        bnd(1'b1, 16'h0003, "R7 first ext0");   do_reti();
        bnd(1'b1, 16'h000B, "R7 then tmr0");    do_reti();
        bnd(1'b1, 16'h0013, "R7 then ext1");    do_reti();
        bnd(1'b1, 16'h001B, "R7 then tmr1");    do_reti();
        check("R9 all cleared", {12'd0, flag_q}, 16'h0000);

        // R3/R6 high first, R4 high not preempted
        wr_ip(5'b01000);
        raise(4'b1001);
        bnd(1'b1, 16'h001B, "R6 high first");
        check("R3 high level", {14'd0, active_lvl}, 16'h0002);
        bnd(1'b0, 16'h0, "R4 high blocks");
        do_reti();
        check("R11 reti high", {14'd0, active_lvl}, 16'h0000);
        bnd(1'b1, 16'h0003, "R6 low after");
        check("R11 low again", {14'd0, active_lvl}, 16'h0001);

        // R4 preemption of low by high
        raise(4'b1000);
        bnd(1'b1, 16'h001B, "R4 preempt");
        check("R11 both", {14'd0, active_lvl}, 16'h0003);
        do_reti();
        check("R11 inner first", {14'd0, active_lvl}, 16'h0001);
        do_reti();
        check("R11 all idle", {14'd0, active_lvl}, 16'h0000);

        // R8/R9 serial
        wr_ie(6'b111111);
        wr_ip(5'b00000);
        @(negedge clk); ser_rx_done = 1'b1;
        bnd(1'b1, 16'h0023, "R8 serial vector");
        bnd(1'b0, 16'h0, "R4 serial vs low");
        do_reti();
        bnd(1'b1, 16'h0023, "R9 serial not cleared");
        @(negedge clk); ser_rx_done = 1'b0;
        do_reti();
        @(negedge clk); ser_tx_done = 1'b1;
        bnd(1'b1, 16'h0023, "R8 serial tx");
        @(negedge clk); ser_tx_done = 1'b0;
        do_reti();

        // R10 waits for boundary
        raise(4'b0100);
        repeat (6) @(negedge clk);
        check("R10 still pending", {12'd0, flag_q}, 16'h0004);
        bnd(1'b1, 16'h0013, "R10 boundary accept");
        do_reti();

        // R2 individual enable off
        wr_ie(6'b111011);
        raise(4'b0100);
        bnd(1'b0, 16'h0, "R2 source disabled");
        check("R2 flag held", {12'd0, flag_q}, 16'h0004);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule